// File: doc/BRIEF.md
# Integer Compare and Condition-Field Unit

This unit sits in the execute stage of a 32-bit RISC integer pipeline. In one cycle it compares register operand A with a second operand: register operand B, a sign-extended 16-bit immediate, or a zero-extended 16-bit immediate. The comparison is signed or unsigned, depending on the operation. The outcome is a 4-bit condition code. The code is merged into one of eight 4-bit fields of a 32-bit condition register, which the unit holds. A 3-bit destination index selects the field.

Each code also carries a copy of an externally supplied sticky summary-overflow flag. The instruction's length bit must be 0 for this 32-bit datapath. A request with the length bit set is rejected: the unit raises an illegal-form flag and writes no field.

Top module: `cond_cmp_unit`

## Requirements
- R1: `op_i` selects the operation. Bit 1 set means unsigned (logical) comparison. Bit 0 set means the second operand is `opb_i`; otherwise it comes from `imm_i` and `opb_i` has no effect. Codes: 00 signed immediate, 01 signed register, 10 unsigned immediate, 11 unsigned register.
- R2: For codes 00 and 01 both operands are compared as signed two's-complement numbers.
- R3: For codes 10 and 11 both operands are compared as unsigned numbers.
- R4: For code 00 the 16-bit immediate is sign-extended to 32 bits before the comparison.
- R5: For code 10 the 16-bit immediate is zero-extended to 32 bits before the comparison.
- R6: The written code is {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0. Exactly one of LT, GT and EQ is set, and SO equals `so_i` sampled with the request.
- R7: Field k occupies `cr_o[31-4k:28-4k]`, so field 0 is the most significant nibble. A write changes only the field named by `dest_i`.
- R8: A request with `valid_i` high is applied on the next rising clock edge. While `valid_i` is low, `cr_o` holds its value.
- R9: When `valid_i` and `len_i` are both high, `cr_o` stays unchanged and `illegal_o` is high in the following cycle. After any other cycle, `illegal_o` is low.
- R10: A low `rst_n` at a rising edge clears `cr_o` and `illegal_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Compare request strobe |
| op_i | input | 2 | Operation code (see R1) |
| len_i | input | 1 | Length bit; must be 0 |
| dest_i | input | 3 | Destination field index |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B (register forms) |
| imm_i | input | 16 | Immediate operand |
| so_i | input | 1 | Summary-overflow flag to copy |
| cr_o | output | 32 | Condition register |
| illegal_o | output | 1 | Illegal-form indication for the last request |

## Verification
The only state is the condition register and the illegal flag. Every wrong write therefore appears on `cr_o` at the first edge after the request. It shows up in one of three ways: a wrong nibble in the addressed field, a change in a neighbouring field, or a change when no request or a rejected request was made. The bench keeps a full model of the register. Any such fault is caught at the next sample point and stays visible until that field is written again or reset clears it.

// File: rtl/cmp_pkg.sv
`timescale 1ns/1ps
// Shared types for the compare unit: operation codes and the condition-code layout.
package cmp_pkg;

    // Bit 1: unsigned comparison; bit 0: second operand from the register file.
    typedef enum logic [1:0] {
        OP_SIGNED_IMM   = 2'b00,
        OP_SIGNED_REG   = 2'b01,
        OP_UNSIGNED_IMM = 2'b10,
        OP_UNSIGNED_REG = 2'b11
    } cmp_op_e;

    // Condition code written into one register field, LT most significant.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_code_t;

    localparam int CODE_W = $bits(cond_code_t);

endpackage

// File: rtl/cmp_operand_sel.sv
`timescale 1ns/1ps
// Second-operand selection.
// Chooses the register operand or the extended immediate, as the operation code asks.
// Assumes IMM_W <= DATA_W.
module cmp_operand_sel
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  cmp_op_e           op_i,
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] operand_o
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    // Build both immediate extensions.
    always_comb begin
        imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        imm_zext = {{EXT_W{1'b0}}, imm_i};
    end

    // Pick the operand: register, else zero-extended for unsigned, else sign-extended.
    always_comb begin
        if (op_i[0]) begin
            operand_o = reg_b_i;
        end else if (op_i[1]) begin
            operand_o = imm_zext;
        end else begin
            operand_o = imm_sext;
        end
    end

endmodule

// File: rtl/cmp_core.sv
`timescale 1ns/1ps
// Magnitude comparator producing the condition code.
// Signed or unsigned per request. Purely combinational.
module cmp_core
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              unsigned_i,
    input  logic              so_i,
    output cond_code_t        code_o
);

    logic less;
    logic equal;

    // Less-than in the requested arithmetic; equality is sign-independent.
    always_comb begin
        if (unsigned_i) begin
            less = (a_i < b_i);
        end else begin
            less = ($signed(a_i) < $signed(b_i));
        end
        equal = (a_i == b_i);
    end

    // Assemble the code; greater-than is whatever is neither less nor equal.
    always_comb begin
        code_o.lt = less;
        code_o.eq = equal;
        code_o.gt = ~less & ~equal;
        code_o.so = so_i;
    end

endmodule

// File: rtl/cr_field_merge.sv
`timescale 1ns/1ps
// Field merge: replaces one field of the condition register with a new code.
// Field 0 is the most significant field. Unselected fields pass through.
module cr_field_merge #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    parameter int IDX_W      = $clog2(NUM_FIELDS),
    parameter int CR_W       = NUM_FIELDS * FIELD_W
) (
    input  logic [CR_W-1:0]    cr_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [FIELD_W-1:0] code_i,
    input  logic               wr_en_i,
    output logic [CR_W-1:0]    cr_o
);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int TOP = CR_W - 1 - f * FIELD_W;
        logic hit;
        // Decide whether this field is the write target.
        always_comb hit = wr_en_i && (idx_i == IDX_W'(f));
        // Select new code or keep the old field.
        always_comb cr_o[TOP -: FIELD_W] = hit ? code_i : cr_i[TOP -: FIELD_W];
    end

endmodule

// File: rtl/cond_cmp_unit.sv
`timescale 1ns/1ps
// Integer compare and condition-field unit (top).
// Compares operand A with a register or an immediate and writes the code into a selected field.
// Assumes requests arrive at most one per cycle and that len_i = 1 marks an illegal form.
module cond_cmp_unit
    import cmp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int IMM_W      = 16,
    parameter int NUM_FIELDS = 8,
    parameter int IDX_W      = $clog2(NUM_FIELDS),
    parameter int FIELD_W    = CODE_W,
    parameter int CR_W       = NUM_FIELDS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        op_i,
    input  logic              len_i,
    input  logic [IDX_W-1:0]  dest_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              so_i,
    output logic [CR_W-1:0]   cr_o,
    output logic              illegal_o
);

    cmp_op_e           op;
    logic [DATA_W-1:0] operand_b;
    cond_code_t        code;
    logic              write_ok;
    logic [CR_W-1:0]   cr_next;
    logic [CR_W-1:0]   cr_q;
    logic              illegal_q;

    // Decode the request: typed operation and permission to write.
    always_comb begin
        op       = cmp_op_e'(op_i);
        write_ok = valid_i & ~len_i;
    end

    cmp_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opsel (
        .op_i      (op),
        .reg_b_i   (opb_i),
        .imm_i     (imm_i),
        .operand_o (operand_b)
    );

    cmp_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .a_i        (opa_i),
        .b_i        (operand_b),
        .unsigned_i (op[1]),
        .so_i       (so_i),
        .code_o     (code)
    );

    cr_field_merge #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W),
        .IDX_W      (IDX_W),
        .CR_W       (CR_W)
    ) u_merge (
        .cr_i    (cr_q),
        .idx_i   (dest_i),
        .code_i  (code),
        .wr_en_i (write_ok),
        .cr_o    (cr_next)
    );

    // Register the condition register and the illegal-form flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            cr_q      <= cr_next;
            illegal_q <= valid_i & len_i;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        cr_o      = cr_q;
        illegal_o = illegal_q;
    end

endmodule

// File: rtl/cond_cmp_unit_checker.sv
`timescale 1ns/1ps
// Property checker for cond_cmp_unit, attached by bind.
// Observes only ports and its own small history registers.
module cond_cmp_unit_checker #(
    parameter int DATA_W     = 32,
    parameter int IMM_W      = 16,
    parameter int NUM_FIELDS = 8,
    parameter int IDX_W      = 3,
    parameter int FIELD_W    = 4,
    parameter int CR_W       = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [1:0]        op_i,
    input logic              len_i,
    input logic [IDX_W-1:0]  dest_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic              so_i,
    input logic [CR_W-1:0]   cr_o,
    input logic              illegal_o
);

    logic [IDX_W-1:0]   dest_q;
    logic               rst_d;
    logic [FIELD_W-1:0] wf;

    function automatic logic [FIELD_W-1:0] field_at(logic [CR_W-1:0] cr, logic [IDX_W-1:0] i);
        return cr[CR_W - 1 - FIELD_W * int'(i) -: FIELD_W];
    endfunction

    function automatic logic others_same(logic [CR_W-1:0] a, logic [CR_W-1:0] b,
                                         logic [IDX_W-1:0] i);
        logic same = 1'b1;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (f != int'(i) && a[CR_W-1-FIELD_W*f -: FIELD_W] != b[CR_W-1-FIELD_W*f -: FIELD_W])
                same = 1'b0;
        end
        return same;
    endfunction

    // Remember the last destination and reset level.
    always_ff @(posedge clk) begin
        dest_q <= dest_i;
        rst_d  <= rst_n;
    end

    // Field addressed by the previous request.
    always_comb wf = field_at(cr_o, dest_q);

    // R10: one edge after reset, the register and the flag are clear.
    always_ff @(posedge clk) begin
        if (rst_d == 1'b0) begin
            p_reset_clear_r10: assert (cr_o == '0 && !illegal_o);
        end
    end

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(cr_o));

    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && len_i) |=> (illegal_o && $stable(cr_o)));

    p_illegal_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && len_i) |=> !illegal_o);

    p_code_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !len_i) |=> ($countones(wf[FIELD_W-1:1]) == 1));

    p_so_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !len_i) |=> (wf[0] == $past(so_i)));

    p_others_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !len_i) |=> others_same(cr_o, $past(cr_o), dest_q));

    p_signed_lt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !len_i && op_i == 2'b01 && $signed(opa_i) < $signed(opb_i)) |=> wf[FIELD_W-1]);

    p_unsigned_lt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !len_i && op_i == 2'b11 && opa_i < opb_i) |=> wf[FIELD_W-1]);

endmodule

bind cond_cmp_unit cond_cmp_unit_checker #(
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W),
    .NUM_FIELDS (NUM_FIELDS),
    .IDX_W      (IDX_W),
    .FIELD_W    (FIELD_W),
    .CR_W       (CR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .len_i     (len_i),
    .dest_i    (dest_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .so_i      (so_i),
    .cr_o      (cr_o),
    .illegal_o (illegal_o)
);

// File: tb/test_cond_cmp_unit.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random requests against a reference model.
module test_cond_cmp_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [1:0]  op_i;
    logic        len_i;
    logic [2:0]  dest_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic [15:0] imm_i;
    logic        so_i;
    logic [31:0] cr_o;
    logic        illegal_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] cr_exp;
    logic        ill_exp;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cond_cmp_unit i_cond_cmp_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .len_i     (len_i),
        .dest_i    (dest_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .imm_i     (imm_i),
        .so_i      (so_i),
        .cr_o      (cr_o),
        .illegal_o (illegal_o)
    );

    // Reference code from the requirements R1-style decode, written independently.
    function automatic logic [3:0] ref_code(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                                            logic [15:0] imm, logic so);
        logic [31:0] y;
        logic        lt;
        if (op == 2'b01 || op == 2'b11) y = b;
        else if (op == 2'b00)           y = {{16{imm[15]}}, imm};
        else                            y = {16'h0000, imm};
        if (op[1]) lt = a < y;
        else       lt = $signed(a) < $signed(y);
        if (a == y)  return {1'b0, 1'b0, 1'b1, so};
        else if (lt) return {1'b1, 1'b0, 1'b0, so};
        else         return {1'b0, 1'b1, 1'b0, so};
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (cr_o !== cr_exp || illegal_o !== ill_exp) begin
            n_err++;
            $display("FAIL %s: cr=%h illegal=%b, expected cr=%h illegal=%b",
                     tag, cr_o, illegal_o, cr_exp, ill_exp);
        end
    endtask

    // Starts at a falling edge, drives one cycle, checks at the next falling edge.
    task automatic apply(logic v, logic [1:0] op, logic l, logic [2:0] d, logic [31:0] a,
                         logic [31:0] b, logic [15:0] imm, logic so, string tag);
        valid_i = v; op_i = op; len_i = l; dest_i = d;
        opa_i = a; opb_i = b; imm_i = imm; so_i = so;
        if (v && !l) cr_exp[31 - 4*int'(d) -: 4] = ref_code(op, a, b, imm, so);
        ill_exp = v && l;
        @(negedge clk);
        check(tag);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; valid_i = 1'b0; op_i = '0; len_i = 1'b0; dest_i = '0;
        opa_i = '0; opb_i = '0; imm_i = '0; so_i = 1'b0;
        cr_exp = '0; ill_exp = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset state");
        rst_n = 1'b1;

        // Directed corners.
        apply(1, 2'b01, 0, 3'd0, 32'd5, 32'd5, 16'h0, 0, "R2 signed equal to field 0");
        apply(1, 2'b01, 0, 3'd3, 32'h8000_0000, 32'd1, 16'h0, 0, "R2 signed negative below one");
        apply(1, 2'b11, 0, 3'd4, 32'h8000_0000, 32'd1, 16'h0, 0, "R3 unsigned large above one");
        apply(1, 2'b00, 0, 3'd7, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 0, "R4 sign-extended immediate equal");
        apply(1, 2'b10, 0, 3'd6, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 0, "R5 zero-extended immediate below");
        apply(1, 2'b00, 0, 3'd1, 32'h0000_8000, 32'h0000_8000, 16'h8000, 0, "R1 immediate form ignores opb");
        apply(1, 2'b01, 0, 3'd2, 32'd9, 32'd3, 16'h0, 1, "R6 summary overflow copied");
        apply(1, 2'b11, 1, 3'd0, 32'd1, 32'd2, 16'h0, 1, "R9 length bit rejected");
        apply(0, 2'b11, 0, 3'd0, 32'd1, 32'd2, 16'h0, 1, "R8 idle keeps register, R9 flag drops");
        apply(1, 2'b10, 0, 3'd5, 32'd0, 32'd0, 16'h0001, 0, "R7 field 5 only");

        // Seeded random traffic.
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = ($urandom_range(0, 3) == 0) ? a : $urandom;
            logic [15:0] im = ($urandom_range(0, 3) == 0) ? a[15:0] : 16'($urandom);
            apply(($urandom_range(0, 7) != 0), 2'($urandom), ($urandom_range(0, 9) == 0),
                  3'($urandom), a, b, im, 1'($urandom), "R7 random request");
        end

        // Reset in mid-run.
        rst_n = 1'b0; valid_i = 1'b1; len_i = 1'b1;
        cr_exp = '0; ill_exp = 1'b0;
        @(negedge clk);
        check("R10 reset during traffic");
        rst_n = 1'b1; valid_i = 1'b0; len_i = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule